// File: doc/BRIEF.md
# Hierarchical DMA Unit Sequencer

This block follows one DMA channel through a three-level work hierarchy. Elements are grouped into fragments, fragments into blocks, and blocks into a transaction. A transfer engine that moves the data pulses a beat input once for every element it moves. The sequencer counts these beats and signals when a fragment, a block or a whole transaction has finished. A request strobe starts the channel. The configured request mode sets how much work that one request covers. When the unit is complete the channel falls idle and waits for the next strobe.

All three sizes are given in elements. A fragment ends after its own length or at the end of its block, whichever comes first, so the last fragment of a block may be short. The same rule holds for blocks inside a transaction. Each completion event is also recorded in a sticky status register. An interrupt line is raised from the status bits that the configured interrupt type selects. A request made with an impossible size set is refused, and only a configuration-error status bit records it.

Top module: `dma_unit_seq`

## Requirements
- R1: After reset, busy, irq, all done pulses and all five status bits are 0.
- R2: A request while idle is refused when any of fragLen, blkLen or trnLen is zero, when fragLen > blkLen, or when blkLen > trnLen. A refused request sets status bit 4, busy stays 0, and no done pulse follows even if beats arrive.
- R3: fragDone pulses for one cycle, in the cycle after the edge that accepts the beat completing fragLen elements of the current fragment, or the last element of the current block.
- R4: blkDone pulses in the cycle after the beat completing blkLen elements of the current block, or the last element of the transaction. Every blkDone coincides with a fragDone.
- R5: trnDone pulses in the cycle after the trnLen-th beat of the transaction and coincides with a blkDone. All counts then restart from zero.
- R6: reqMode selects the unit of work: 0 is a fragment, 1 is a block, 2 is a transaction and 3 is a list. An accepted request raises busy in the next cycle, and busy falls in the cycle its unit's done pulse appears. In mode 3, listDone pulses together with trnDone.
- R7: Beats while idle and request strobes while busy have no effect.
- R8: While idle between requests the counters hold their values, so the next request continues the partly finished block and transaction.
- R9: Status bits are bit0 fragment, bit1 block, bit2 transaction, bit3 list and bit4 configuration error. They set on the matching event and stay set until a 1 is written to the same bit of intClr. A set in the same cycle as a clear wins.
- R10: irq is the OR of the status bits enabled by intType: 0 none, 1 fragment, 2 block, 4 transaction, 7 list, 8 configuration error, and any other value none.
- R11: The combined types enable two bits: 3 enables block and fragment, 5 enables transaction and fragment, and 6 enables transaction and block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqMode | input | 2 | Unit of work per request |
| intType | input | 4 | Interrupt type selector |
| fragLen | input | W | Elements per fragment |
| blkLen | input | W | Elements per block |
| trnLen | input | W | Elements per transaction |
| reqStrobe | input | 1 | Start request |
| beat | input | 1 | One element moved |
| intClr | input | 5 | Write-one-to-clear for status bits |
| busy | output | 1 | Channel is working on a request |
| fragDone | output | 1 | Fragment complete pulse |
| blkDone | output | 1 | Block complete pulse |
| trnDone | output | 1 | Transaction complete pulse |
| listDone | output | 1 | List complete pulse |
| irq | output | 1 | Interrupt line |
| intStatus | output | 5 | Sticky interrupt status |

## Verification
The assertions check on every cycle that the hierarchy stays nested: each block end is also a fragment end, each transaction end is also a block end, and each list end is also a transaction end. They also check that done pulses and the fall of busy only follow an accepted beat, that the error bit rises only on a refused idle request, that status bits are sticky, and that irq has a set bit behind it. Only the bench scenarios can show the exact number of beats each mode consumes and the count of short trailing fragments. They alone show that counters carry over between requests and which status bits each intType value lets through to irq.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int STAT_W = 5;

  typedef enum logic [1:0] {
    UNIT_FRAG = 2'd0,
    UNIT_BLK  = 2'd1,
    UNIT_TRN  = 2'd2,
    UNIT_LIST = 2'd3
  } unit_e;

  typedef struct packed {
    logic step;
  } seq_strobe_t;

  function automatic logic [STAT_W-1:0] irqMask(input logic [3:0] typ);
    logic [STAT_W-1:0] m;
    case (typ)
      4'd1:    m = 5'b00001;
      4'd2:    m = 5'b00010;
      4'd3:    m = 5'b00011;
      4'd4:    m = 5'b00100;
      4'd5:    m = 5'b00101;
      4'd6:    m = 5'b00110;
      4'd7:    m = 5'b01000;
      4'd8:    m = 5'b10000;
      default: m = 5'b00000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt
  import dma_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [W-1:0] fragLen,
  input  logic [W-1:0] blkLen,
  input  logic [W-1:0] trnLen,
  input  seq_strobe_t strobe,
  output logic        fragEnd,
  output logic        blkEnd,
  output logic        trnEnd,
  output logic        cfgBad
);

  localparam int CW = W + 1;

  logic [W-1:0] fragCnt, blkCnt, trnCnt;

  // End flags describe the beat being accepted now (count + 1 reaches length).
  assign trnEnd  = ({1'b0, trnCnt} + CW'(1)) == {1'b0, trnLen};
  assign blkEnd  = (({1'b0, blkCnt} + CW'(1)) == {1'b0, blkLen}) || trnEnd;
  assign fragEnd = (({1'b0, fragCnt} + CW'(1)) == {1'b0, fragLen}) || blkEnd;

  assign cfgBad = (fragLen == '0) || (blkLen == '0) || (trnLen == '0) ||
                  (fragLen > blkLen) || (blkLen > trnLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fragCnt <= '0;
      blkCnt  <= '0;
      trnCnt  <= '0;
    end else if (strobe.step) begin
      fragCnt <= fragEnd ? '0 : fragCnt + W'(1);
      blkCnt  <= blkEnd  ? '0 : blkCnt + W'(1);
      trnCnt  <= trnEnd  ? '0 : trnCnt + W'(1);
    end
  end

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        reqMode,
  input  logic [3:0]        intType,
  input  logic              reqStrobe,
  input  logic              beat,
  input  logic [STAT_W-1:0] intClr,
  input  logic              fragEnd,
  input  logic              blkEnd,
  input  logic              trnEnd,
  input  logic              cfgBad,
  output seq_strobe_t       strobe,
  output logic              busy,
  output logic              fragDone,
  output logic              blkDone,
  output logic              trnDone,
  output logic              listDone,
  output logic              irq,
  output logic [STAT_W-1:0] intStatus
);

  unit_e modeQ;
  logic  accept, reject, step, unitEnd, listEv;
  logic [STAT_W-1:0] setVec;

  assign accept = reqStrobe && !busy && !cfgBad;
  assign reject = reqStrobe && !busy && cfgBad;
  assign step   = busy && beat;
  assign strobe.step = step;

  always_comb begin
    case (modeQ)
      UNIT_FRAG: unitEnd = fragEnd;
      UNIT_BLK:  unitEnd = blkEnd;
      default:   unitEnd = trnEnd;
    endcase
  end

  assign listEv = step && trnEnd && (modeQ == UNIT_LIST);
  assign setVec = {reject, listEv, step && trnEnd, step && blkEnd, step && fragEnd};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      modeQ     <= UNIT_FRAG;
      fragDone  <= 1'b0;
      blkDone   <= 1'b0;
      trnDone   <= 1'b0;
      listDone  <= 1'b0;
      intStatus <= '0;
    end else begin
      if (accept) begin
        busy  <= 1'b1;
        modeQ <= unit_e'(reqMode);
      end else if (step && unitEnd) begin
        busy <= 1'b0;
      end
      fragDone  <= setVec[0];
      blkDone   <= setVec[1];
      trnDone   <= setVec[2];
      listDone  <= setVec[3];
      intStatus <= (intStatus & ~intClr) | setVec;
    end
  end

  assign irq = |(intStatus & irqMask(intType));

endmodule

// File: rtl/dma_unit_seq.sv
module dma_unit_seq
  import dma_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   reqMode,
  input  logic [3:0]   intType,
  input  logic [W-1:0] fragLen,
  input  logic [W-1:0] blkLen,
  input  logic [W-1:0] trnLen,
  input  logic         reqStrobe,
  input  logic         beat,
  input  logic [4:0]   intClr,
  output logic         busy,
  output logic         fragDone,
  output logic         blkDone,
  output logic         trnDone,
  output logic         listDone,
  output logic         irq,
  output logic [4:0]   intStatus
);

  seq_strobe_t strobe;
  logic fragEnd, blkEnd, trnEnd, cfgBad;

  dma_seq_cnt #(.W(W)) uCnt (
    .clk(clk), .rstN(rstN),
    .fragLen(fragLen), .blkLen(blkLen), .trnLen(trnLen),
    .strobe(strobe),
    .fragEnd(fragEnd), .blkEnd(blkEnd), .trnEnd(trnEnd), .cfgBad(cfgBad)
  );

  dma_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .reqMode(reqMode), .intType(intType),
    .reqStrobe(reqStrobe), .beat(beat), .intClr(intClr),
    .fragEnd(fragEnd), .blkEnd(blkEnd), .trnEnd(trnEnd), .cfgBad(cfgBad),
    .strobe(strobe), .busy(busy),
    .fragDone(fragDone), .blkDone(blkDone), .trnDone(trnDone), .listDone(listDone),
    .irq(irq), .intStatus(intStatus)
  );

endmodule

// File: rtl/dma_unit_seq_chk.sv
module dma_unit_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqStrobe,
  input logic       beat,
  input logic [4:0] intClr,
  input logic       busy,
  input logic       fragDone,
  input logic       blkDone,
  input logic       trnDone,
  input logic       listDone,
  input logic       irq,
  input logic [4:0] intStatus
);

  assert_frag_after_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    fragDone |-> ($past(busy) && $past(beat)));

  assert_blk_nests_frag_R4: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |-> fragDone);

  assert_trn_nests_blk_R5: assert property (@(posedge clk) disable iff (!rstN)
    trnDone |-> blkDone);

  assert_list_with_trn_R6: assert property (@(posedge clk) disable iff (!rstN)
    listDone |-> trnDone);

  assert_busy_falls_on_beat_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(beat) && (fragDone || blkDone || trnDone)));

  assert_err_only_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[4]) |-> (!busy && $past(!busy) && $past(reqStrobe)));

  assert_sticky_frag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[0] && !intClr[0]) |=> intStatus[0]);

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intStatus != 5'b0));

endmodule

bind dma_unit_seq dma_unit_seq_chk uChk (
  .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .beat(beat), .intClr(intClr),
  .busy(busy), .fragDone(fragDone), .blkDone(blkDone), .trnDone(trnDone),
  .listDone(listDone), .irq(irq), .intStatus(intStatus)
);

// File: tb/tb_dma_unit_seq.sv
module tb_dma_unit_seq;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   reqMode = '0;
  logic [3:0]   intType = '0;
  logic [W-1:0] fragLen = '0, blkLen = '0, trnLen = '0;
  logic         reqStrobe = 1'b0, beat = 1'b0;
  logic [4:0]   intClr = '0;
  logic         busy, fragDone, blkDone, trnDone, listDone, irq;
  logic [4:0]   intStatus;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_unit_seq #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .reqMode(reqMode), .intType(intType),
    .fragLen(fragLen), .blkLen(blkLen), .trnLen(trnLen),
    .reqStrobe(reqStrobe), .beat(beat), .intClr(intClr),
    .busy(busy), .fragDone(fragDone), .blkDone(blkDone), .trnDone(trnDone),
    .listDone(listDone), .irq(irq), .intStatus(intStatus)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] typ;
    logic [7:0] fl, bl, tl;
    logic [7:0] nBeat, nFrag, nBlk, nTrn, nList;
    logic [4:0] stat;
    logic       irqExp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd1, 8'd3, 8'd8, 8'd20, 8'd3,  8'd1, 8'd0, 8'd0, 8'd0, 5'b00001, 1'b1},
    '{2'd1, 4'd4, 8'd3, 8'd8, 8'd20, 8'd8,  8'd3, 8'd1, 8'd0, 8'd0, 5'b00011, 1'b0},
    '{2'd2, 4'd6, 8'd3, 8'd8, 8'd20, 8'd20, 8'd8, 8'd3, 8'd1, 8'd0, 5'b00111, 1'b1},
    '{2'd3, 4'd7, 8'd4, 8'd4, 8'd8,  8'd8,  8'd2, 8'd2, 8'd1, 8'd1, 5'b01111, 1'b1},
    '{2'd2, 4'd5, 8'd1, 8'd1, 8'd1,  8'd1,  8'd1, 8'd1, 8'd1, 8'd0, 5'b00111, 1'b1},
    '{2'd2, 4'd2, 8'd5, 8'd5, 8'd5,  8'd5,  8'd1, 8'd1, 8'd1, 8'd0, 5'b00111, 1'b1},
    '{2'd0, 4'd3, 8'd2, 8'd2, 8'd4,  8'd2,  8'd1, 8'd1, 8'd0, 8'd0, 5'b00011, 1'b1},
    '{2'd1, 4'd0, 8'd2, 8'd6, 8'd6,  8'd6,  8'd3, 8'd1, 8'd1, 8'd0, 5'b00111, 1'b0},
    '{2'd2, 4'd8, 8'd0, 8'd4, 8'd8,  8'd0,  8'd0, 8'd0, 8'd0, 8'd0, 5'b10000, 1'b1},
    '{2'd2, 4'd1, 8'd5, 8'd4, 8'd8,  8'd0,  8'd0, 8'd0, 8'd0, 8'd0, 5'b10000, 1'b0},
    '{2'd1, 4'd8, 8'd2, 8'd9, 8'd8,  8'd0,  8'd0, 8'd0, 8'd0, 8'd0, 5'b10000, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqStrobe = 1'b0; beat = 1'b0; intClr = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic request(input logic [1:0] m);
    reqMode = m;
    reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
  endtask

  // Beats while busy; returns beats consumed and done-pulse counts.
  task automatic pump(input int maxBeats, output int nb, output int nf,
                      output int nk, output int nt, output int nl);
    nb = 0; nf = 0; nk = 0; nt = 0; nl = 0;
    for (int i = 0; i < maxBeats; i++) begin
      if (!busy) break;
      beat = 1'b1;
      @(negedge clk);
      nb++;
      nf += int'(fragDone); nk += int'(blkDone);
      nt += int'(trnDone);  nl += int'(listDone);
    end
    beat = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int nb, nf, nk, nt, nl;
    bit isErr, isComb;

    // R1 reset state
    doReset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 status", int'(intStatus), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 pulses", int'({fragDone, blkDone, trnDone, listDone}), 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      doReset();
      intType = VECS[v].typ;
      fragLen = W'(VECS[v].fl); blkLen = W'(VECS[v].bl); trnLen = W'(VECS[v].tl);
      isErr  = (VECS[v].stat[4] == 1'b1);
      isComb = (VECS[v].typ == 4'd3) || (VECS[v].typ == 4'd5) || (VECS[v].typ == 4'd6);
      request(VECS[v].mode);
      if (isErr) begin
        chk("R2 busy stays low", int'(busy), 0);
        // beats after a refused request must do nothing
        for (int i = 0; i < 3; i++) begin
          beat = 1'b1;
          @(negedge clk);
          chk("R2 no pulse", int'({fragDone, blkDone, trnDone, listDone}), 0);
        end
        beat = 1'b0;
        chk("R2 status", int'(intStatus), int'(VECS[v].stat));
        chk("R2 busy", int'(busy), 0);
      end else begin
        chk("R6 busy rises", int'(busy), 1);
        pump(200, nb, nf, nk, nt, nl);
        chk("R6 beats per request", nb, int'(VECS[v].nBeat));
        chk("R3 frag pulses", nf, int'(VECS[v].nFrag));
        chk("R4 blk pulses", nk, int'(VECS[v].nBlk));
        chk("R5 trn pulses", nt, int'(VECS[v].nTrn));
        chk("R6 list pulses", nl, int'(VECS[v].nList));
        chk("R9 status", int'(intStatus), int'(VECS[v].stat));
      end
      if (isComb) chk("R11 combined irq", int'(irq), int'(VECS[v].irqExp));
      else        chk("R10 irq", int'(irq), int'(VECS[v].irqExp));
    end

    // R7: idle beats ignored, request while busy ignored
    doReset();
    intType = 4'd1;
    fragLen = 16'd3; blkLen = 16'd8; trnLen = 16'd20;
    beat = 1'b1;
    repeat (4) @(negedge clk);
    beat = 1'b0;
    chk("R7 idle beats no pulse", int'(intStatus), 0);
    request(2'd0);
    beat = 1'b1;
    @(negedge clk);
    beat = 1'b0;
    reqMode = 2'd2;
    reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
    pump(50, nb, nf, nk, nt, nl);
    chk("R7 remaining beats after busy request", nb, 2);
    chk("R7 one fragment", nf, 1);

    // R8: counters held across idle; block remainder resumes
    request(2'd0);
    pump(50, nb, nf, nk, nt, nl);
    chk("R8 second fragment beats", nb, 3);
    request(2'd1);
    pump(50, nb, nf, nk, nt, nl);
    chk("R8 block remainder beats", nb, 2);
    chk("R8 block done", nk, 1);

    // R9: write-one-to-clear of bit0 only, irq follows
    chk("R9 status before clear", int'(intStatus), 5'b00011);
    chk("R10 irq before clear", int'(irq), 1);
    intClr = 5'b00001;
    @(negedge clk);
    intClr = '0;
    chk("R9 status after clear", int'(intStatus), 5'b00010);
    chk("R10 irq after clear", int'(irq), 0);
    @(negedge clk);
    chk("R9 sticky", int'(intStatus), 5'b00010);

    // R9: set wins over clear in the same cycle
    request(2'd0);
    pump(2, nb, nf, nk, nt, nl);
    beat = 1'b1;
    intClr = 5'b00001;
    @(negedge clk);
    beat = 1'b0;
    intClr = '0;
    chk("R9 set wins", int'(intStatus[0]), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule